// File: doc/BRIEF.md
# Dual-Rate Priority Memory Arbiter

This block shares one memory port between two requesters: a general-purpose processor stream and a timing-critical chipset DMA stream. Both requesters post their accesses in a request clock domain. The accesses are carried out in an execution domain that runs at exactly twice that rate, with its rising edges aligned to those of the request clock. Each requester owns a one-entry slot. A post loads the slot and flips a request toggle. The execution side takes a slot by flipping a matching accept toggle. The request side compares the two toggles, so a slot that was already taken is never issued a second time.

The execution side keeps at most one transaction open on the memory port. It gives the DMA stream precedence. A processor access that has waited through a DMA transaction is owed the next slot, unless the run-time exclusive switch is on. When the switch is on, the processor waits as long as any DMA request is pending. Each open transaction carries a one-bit source tag. The tag steers the returned data and a completion toggle back to the requester that issued it, and that requester sees a one-cycle ready pulse in the request domain.

Top module: `dual_rate_mem_arbiter`

## Requirements
- R1: While reset is asserted and directly after it is released, `cpu_ready`, `dma_ready` and `mem_valid` are low.
- R2: A processor access completes on the memory port. A read returns the byte stored at its address and a write updates that byte. Each access produces exactly one `cpu_ready` pulse, one request-clock cycle wide.
- R3: When processor and DMA requests are posted in the same request-clock cycle while the port is idle, the DMA access is presented on the memory port first.
- R4: A processor request posted while a DMA transaction is in flight is held, not dropped. It is served once that transaction completes and sees the DMA's write. A requester posts again only after its previous post has been taken.
- R5: Every posted request produces exactly one memory transaction, so no request is served twice.
- R6: DMA read data and `dma_ready` appear only on the DMA port. `dma_rdata` keeps the last DMA result across processor accesses, and a DMA access never pulses `cpu_ready`.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. Every transaction, writes included, is acknowledged to its requester.
- R8: With `dma_excl` low, a processor request that waited through a DMA transaction is granted before a second DMA request that is pending at the same time. The memory order is DMA, processor, DMA.
- R9: With `dma_excl` high, no processor access is granted while a DMA request is pending. The same scenario as R8 runs in the order DMA, DMA, processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Request-domain clock |
| clk_exec | input | 1 | Execution clock, twice clk_req, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dma_excl | input | 1 | 1: DMA blocks processor grants while pending |
| cpu_req | input | 1 | Processor post strobe, one request cycle |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Processor completion pulse |
| cpu_rdata | output | DATA_W | Processor read data, valid with cpu_ready |
| dma_req | input | 1 | DMA post strobe, one request cycle |
| dma_we | input | 1 | DMA write enable |
| dma_addr | input | ADDR_W | DMA address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_ready | output | 1 | DMA completion pulse |
| dma_rdata | output | DATA_W | DMA read data, valid with dma_ready |
| mem_valid | output | 1 | Transaction open on the memory port |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completion, one execution cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |

## Verification
A table of processor reads and writes to distinct addresses checks the basic path. It tells a correct store from a stale or misrouted byte. A lone DMA read followed by a processor read shows whether data leaks between the two ports. Simultaneous posts check the tie-break. A processor read of a location that an in-flight DMA is writing shows whether the held request runs after that write. The same three-request overlap is run with the exclusive switch off and then on. Checking the recorded memory order and the transaction count then separates the owed-slot rule from absolute DMA precedence, and exposes any double service.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DMA = 1'b1
    } src_e;

    localparam int NUM_SRC = 2;
    localparam int IDX_CPU = 0;
    localparam int IDX_DMA = 1;
endpackage

// File: rtl/arb_src_port.sv
// One requester's slot in the request clock domain: post toggle, slot
// contents and the completion pulse taken from the execution side.
module arb_src_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              acc_tgl_i,
    input  logic              rsp_tgl_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              post_tgl_o,
    output logic              slot_we_o,
    output logic [ADDR_W-1:0] slot_addr_o,
    output logic [DATA_W-1:0] slot_wdata_o,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic              tgl;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              seen;
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t st_d, st_q;
    logic  slot_free;

    assign slot_free = (st_q.tgl == acc_tgl_i);

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        if (req_i && slot_free) begin
            st_d.tgl   = ~st_q.tgl;
            st_d.we    = we_i;
            st_d.addr  = addr_i;
            st_d.wdata = wdata_i;
        end
        if (rsp_tgl_i != st_q.seen) begin
            st_d.seen  = rsp_tgl_i;
            st_d.ready = 1'b1;
            st_d.rdata = rsp_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign post_tgl_o   = st_q.tgl;
    assign slot_we_o    = st_q.we;
    assign slot_addr_o  = st_q.addr;
    assign slot_wdata_o = st_q.wdata;
    assign ready_o      = st_q.ready;
    assign rdata_o      = st_q.rdata;

    // A post onto an occupied slot would be lost.
    assert_post_slot_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> slot_free);

    // Completion is a single-cycle pulse.
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready |=> !st_q.ready);
endmodule

// File: rtl/arb_exec_side.sv
// Execution domain (2x clock): grant, one open transaction, tagged return.
module arb_exec_side
    import mem_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             dma_excl_i,
    input  logic [NUM_SRC-1:0]               post_tgl_i,
    input  logic [NUM_SRC-1:0]               slot_we_i,
    input  logic [NUM_SRC-1:0][ADDR_W-1:0]   slot_addr_i,
    input  logic [NUM_SRC-1:0][DATA_W-1:0]   slot_wdata_i,
    input  logic                             mem_ready_i,
    input  logic [DATA_W-1:0]                mem_rdata_i,
    output logic [NUM_SRC-1:0]               acc_tgl_o,
    output logic [NUM_SRC-1:0]               rsp_tgl_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   rsp_data_o,
    output logic                             mem_valid_o,
    output logic                             mem_we_o,
    output logic [ADDR_W-1:0]                mem_addr_o,
    output logic [DATA_W-1:0]                mem_wdata_o
);
    typedef struct packed {
        logic                           busy;
        src_e                           tag;
        logic                           we;
        logic [ADDR_W-1:0]              addr;
        logic [DATA_W-1:0]              wdata;
        logic [NUM_SRC-1:0]             acc;
        logic [NUM_SRC-1:0]             rsp_tgl;
        logic [NUM_SRC-1:0][DATA_W-1:0] rsp;
        logic                           owed;
    } exec_t;

    exec_t              ex_d, ex_q;
    logic [NUM_SRC-1:0] pend;
    logic               grant_dma, grant_cpu;
    logic               sel, tag_idx;

    assign pend      = post_tgl_i ^ ex_q.acc;
    assign grant_dma = pend[IDX_DMA] && !(pend[IDX_CPU] && ex_q.owed && !dma_excl_i);
    assign grant_cpu = pend[IDX_CPU] && !grant_dma;
    assign sel       = grant_dma;
    assign tag_idx   = ex_q.tag;

    always_comb begin
        ex_d = ex_q;
        if (ex_q.busy) begin
            if (pend[IDX_CPU] && ex_q.tag == SRC_DMA) ex_d.owed = 1'b1;
            if (mem_ready_i) begin
                ex_d.busy             = 1'b0;
                ex_d.rsp_tgl[tag_idx] = ~ex_q.rsp_tgl[tag_idx];
                ex_d.rsp[tag_idx]     = mem_rdata_i;
            end
        end else if (grant_dma || grant_cpu) begin
            ex_d.busy     = 1'b1;
            ex_d.tag      = sel ? SRC_DMA : SRC_CPU;
            ex_d.we       = slot_we_i[sel];
            ex_d.addr     = slot_addr_i[sel];
            ex_d.wdata    = slot_wdata_i[sel];
            ex_d.acc[sel] = ~ex_q.acc[sel];
            if (grant_cpu) ex_d.owed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ex_q <= '0;
        else        ex_q <= ex_d;
    end

    assign acc_tgl_o   = ex_q.acc;
    assign rsp_tgl_o   = ex_q.rsp_tgl;
    assign rsp_data_o  = ex_q.rsp;
    assign mem_valid_o = ex_q.busy;
    assign mem_we_o    = ex_q.we;
    assign mem_addr_o  = ex_q.addr;
    assign mem_wdata_o = ex_q.wdata;

    assert_port_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ex_q.busy && !mem_ready_i |=> ex_q.busy && $stable(ex_q.addr)
                                      && $stable(ex_q.we) && $stable(ex_q.wdata));

    assert_tie_dma_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_q.busy && pend[IDX_DMA] && pend[IDX_CPU] && !ex_q.owed
        |=> ex_q.busy && ex_q.tag == SRC_DMA);

    assert_excl_blocks_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_q.busy && dma_excl_i && pend[IDX_DMA] |=> ex_q.tag == SRC_DMA);

    assert_cpu_rsp_not_on_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_q.busy && mem_ready_i && ex_q.tag == SRC_CPU
        |=> $stable(ex_q.rsp[IDX_DMA]) && $stable(ex_q.rsp_tgl[IDX_DMA]));

    assert_accept_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ex_q.acc ^ $past(ex_q.acc)) <= 1);

    assert_accept_opens_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_q.acc != $past(ex_q.acc) |-> ex_q.busy && !$past(ex_q.busy));
endmodule

// File: rtl/dual_rate_mem_arbiter.sv
module dual_rate_mem_arbiter
    import mem_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk_req,
    input  logic              clk_exec,
    input  logic              rst_n,
    input  logic              dma_excl,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_ready,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [NUM_SRC-1:0]             src_req, src_we, post_tgl, slot_we;
    logic [NUM_SRC-1:0]             acc_tgl, rsp_tgl, src_ready;
    logic [NUM_SRC-1:0][ADDR_W-1:0] src_addr, slot_addr;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_wdata, slot_wdata, rsp_data, src_rdata;

    assign src_req[IDX_CPU]   = cpu_req;
    assign src_we[IDX_CPU]    = cpu_we;
    assign src_addr[IDX_CPU]  = cpu_addr;
    assign src_wdata[IDX_CPU] = cpu_wdata;
    assign src_req[IDX_DMA]   = dma_req;
    assign src_we[IDX_DMA]    = dma_we;
    assign src_addr[IDX_DMA]  = dma_addr;
    assign src_wdata[IDX_DMA] = dma_wdata;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_port
        arb_src_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk          (clk_req),
            .rst_n        (rst_n),
            .req_i        (src_req[s]),
            .we_i         (src_we[s]),
            .addr_i       (src_addr[s]),
            .wdata_i      (src_wdata[s]),
            .acc_tgl_i    (acc_tgl[s]),
            .rsp_tgl_i    (rsp_tgl[s]),
            .rsp_data_i   (rsp_data[s]),
            .post_tgl_o   (post_tgl[s]),
            .slot_we_o    (slot_we[s]),
            .slot_addr_o  (slot_addr[s]),
            .slot_wdata_o (slot_wdata[s]),
            .ready_o      (src_ready[s]),
            .rdata_o      (src_rdata[s])
        );
    end

    arb_exec_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
        .clk          (clk_exec),
        .rst_n        (rst_n),
        .dma_excl_i   (dma_excl),
        .post_tgl_i   (post_tgl),
        .slot_we_i    (slot_we),
        .slot_addr_i  (slot_addr),
        .slot_wdata_i (slot_wdata),
        .mem_ready_i  (mem_ready),
        .mem_rdata_i  (mem_rdata),
        .acc_tgl_o    (acc_tgl),
        .rsp_tgl_o    (rsp_tgl),
        .rsp_data_o   (rsp_data),
        .mem_valid_o  (mem_valid),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata)
    );

    assign cpu_ready = src_ready[IDX_CPU];
    assign cpu_rdata = src_rdata[IDX_CPU];
    assign dma_ready = src_ready[IDX_DMA];
    assign dma_rdata = src_rdata[IDX_DMA];
endmodule

// File: tb/tb_dual_rate_mem_arbiter.sv
module tb_dual_rate_mem_arbiter;
    logic        clk_req = 1'b0;
    logic        clk_exec = 1'b1;
    logic        rst_n = 1'b0;
    logic        dma_excl = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        dma_req = 1'b0, dma_we = 1'b0;
    logic [15:0] dma_addr = '0;
    logic [7:0]  dma_wdata = '0;
    logic        dma_ready;
    logic [7:0]  dma_rdata;
    logic        mem_valid, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #4 clk_exec = ~clk_exec;   // 125 MHz, rising at 8, 16, 24 ...
    always #8 clk_req  = ~clk_req;    // half rate, rising at 8, 24, 40 ...

    dual_rate_mem_arbiter #(.ADDR_W(16), .DATA_W(8)) dut (
        .clk_req(clk_req), .clk_exec(clk_exec), .rst_n(rst_n), .dma_excl(dma_excl),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_ready(dma_ready), .dma_rdata(dma_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model: 16 bytes, ready in the fourth cycle of an open transaction.
    logic [7:0]  mem [16];
    logic [15:0] log_addr [32];
    int          log_n = 0;
    int          cnt = 0;
    always @(posedge clk_exec) begin
        if (!rst_n) begin
            cnt <= 0; mem_ready <= 1'b0; log_n <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 8'h30 + 8'(i);
        end else if (mem_ready) begin
            mem_ready <= 1'b0; cnt <= 0;
            if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
            log_addr[log_n % 32] <= mem_addr;
            log_n <= log_n + 1;
        end else if (mem_valid) begin
            if (cnt == 2) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem[mem_addr[3:0]];
            end else cnt <= cnt + 1;
        end
    end

    // Ready monitor, sampled mid-way through the high phase of clk_req.
    int         cpu_cnt = 0, dma_cnt = 0;
    logic [7:0] cpu_last = '0, dma_last = '0;
    always @(negedge clk_exec) begin
        if (rst_n && clk_req) begin
            if (cpu_ready) begin cpu_cnt <= cpu_cnt + 1; cpu_last <= cpu_rdata; end
            if (dma_ready) begin dma_cnt <= dma_cnt + 1; dma_last <= dma_rdata; end
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic post(input bit c_en, input bit c_we, input logic [15:0] c_a, input logic [7:0] c_d,
                        input bit d_en, input bit d_we, input logic [15:0] d_a, input logic [7:0] d_d);
        @(negedge clk_req);
        cpu_req = c_en; cpu_we = c_we; cpu_addr = c_a; cpu_wdata = c_d;
        dma_req = d_en; dma_we = d_we; dma_addr = d_a; dma_wdata = d_d;
        @(negedge clk_req);
        cpu_req = 1'b0; dma_req = 1'b0;
    endtask

    task automatic wait_cnt(input int c, input int d, input string req);
        int n = 0;
        while ((cpu_cnt < c || dma_cnt < d) && n < 200) begin
            @(negedge clk_req); n++;
        end
        chk(cpu_cnt == c && dma_cnt == d, req, 32'(cpu_cnt * 256 + dma_cnt), 32'(c * 256 + d));
    endtask

    // {we, addr, wdata, expected read data}
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 16'h0003, 8'hAA, 8'h00},
        {1'b1, 16'h0004, 8'h55, 8'h00},
        {1'b0, 16'h0003, 8'h00, 8'hAA},
        {1'b0, 16'h0004, 8'h00, 8'h55},
        {1'b0, 16'h0007, 8'h00, 8'h37},
        {1'b1, 16'h000F, 8'hC3, 8'h00},
        {1'b0, 16'h000F, 8'h00, 8'hC3},
        {1'b0, 16'h0000, 8'h00, 8'h30}
    };

    task automatic order_run(input bit excl, input logic [15:0] a1, input logic [15:0] a2,
                             input logic [15:0] ac, input string req);
        int base, c0, d0;
        dma_excl = excl;
        base = log_n; c0 = cpu_cnt; d0 = dma_cnt;
        post(0, 0, 16'h0, 8'h0, 1, 0, a1, 8'h0);
        post(1, 0, ac, 8'h0, 1, 0, a2, 8'h0);
        wait_cnt(c0 + 1, d0 + 2, req);
        repeat (4) @(negedge clk_req);
        chk(log_n - base == 3, "R5", 32'(log_n - base), 32'd3);
        chk(log_addr[base % 32] == a1, req, 32'(log_addr[base % 32]), 32'(a1));
        if (!excl)
            chk(log_addr[(base + 1) % 32] == ac, req, 32'(log_addr[(base + 1) % 32]), 32'(ac));
        else
            chk(log_addr[(base + 1) % 32] == a2, req, 32'(log_addr[(base + 1) % 32]), 32'(a2));
        chk(cpu_last == 8'h30 + 8'(ac[3:0]), req, 32'(cpu_last), 32'(8'h30 + 8'(ac[3:0])));
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk_req);
        // R1: idle outputs in reset
        chk(!cpu_ready && !dma_ready && !mem_valid, "R1", {cpu_ready, dma_ready, mem_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk_req);
        chk(!cpu_ready && !dma_ready && !mem_valid, "R1", {cpu_ready, dma_ready, mem_valid}, 0);

        // R2, R7: processor table, writes acknowledged too
        for (int i = 0; i < 8; i++) begin
            post(1, VEC[i][32], VEC[i][31:16], VEC[i][15:8], 0, 0, 16'h0, 8'h0);
            wait_cnt(i + 1, 0, "R7");
            if (!VEC[i][32]) chk(cpu_last == VEC[i][7:0], "R2", 32'(cpu_last), 32'(VEC[i][7:0]));
            @(negedge clk_req);
            chk(!cpu_ready, "R2", 32'(cpu_ready), 0);
        end

        // R6: DMA result only on DMA port, kept across processor access
        post(0, 0, 16'h0, 8'h0, 1, 0, 16'h0005, 8'h0);
        wait_cnt(8, 1, "R6");
        chk(dma_last == 8'h35, "R6", 32'(dma_last), 32'h35);
        post(1, 0, 16'h0003, 8'h0, 0, 0, 16'h0, 8'h0);
        wait_cnt(9, 1, "R6");
        chk(cpu_last == 8'hAA, "R2", 32'(cpu_last), 32'hAA);
        chk(dma_rdata == 8'h35, "R6", 32'(dma_rdata), 32'h35);

        // R3: tie in one cycle, DMA first
        base = log_n;
        post(1, 0, 16'h0001, 8'h0, 1, 0, 16'h0002, 8'h0);
        wait_cnt(10, 2, "R3");
        chk(log_addr[base % 32] == 16'h0002, "R3", 32'(log_addr[base % 32]), 32'h2);
        chk(log_n - base == 2, "R5", 32'(log_n - base), 32'd2);
        chk(cpu_last == 8'h31 && dma_last == 8'h32, "R6", {cpu_last, dma_last}, 32'h3132);

        // R4: processor read held behind an in-flight DMA write to the same byte
        base = log_n;
        post(0, 0, 16'h0, 8'h0, 1, 1, 16'h0008, 8'h99);
        post(1, 0, 16'h0008, 8'h0, 0, 0, 16'h0, 8'h0);
        wait_cnt(11, 3, "R4");
        chk(cpu_last == 8'h99, "R4", 32'(cpu_last), 32'h99);
        chk(log_n - base == 2, "R5", 32'(log_n - base), 32'd2);

        // R8 / R9: owed slot versus exclusive DMA precedence
        order_run(1'b0, 16'h0009, 16'h000A, 16'h000B, "R8");
        order_run(1'b1, 16'h000C, 16'h000D, 16'h000E, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule